// File: doc/BRIEF.md
# Fill Buffer Event Counter

This block is one programmable performance counter that sits beside the fill buffer tracker of a first-level data cache. Every cycle the tracker supplies three counts: the demand-load line misses that are still outstanding, the requests turned away because no fill buffer was free, and the fill buffers newly allocated (writeback allocations included). Software programs an event selector, a sub-event mask and a threshold through a small register port, and then reads the accumulated 48-bit count.

One event selector value carries a whole family of sub-events, and the mask bits pick which tracker counts are summed. With the threshold at zero the counter accumulates the selected value itself, so an occupancy input measures occupancy summed over cycles. With a nonzero threshold the counter adds one for each cycle in which the selected value reaches the threshold, which turns the same input into a count of busy cycles. Counting follows the tracker directly, so work on mis-speculated paths is counted too; no retirement signal gates it.

The register port is a single-cycle write strobe with an address, plus a combinational read path selected by its own address. The count wraps at 2^48 and records the wrap in a sticky flag.

Top module: `fb_event_counter`

## Requirements
- R1: After reset the control register, the count and the wrap flag all read as zero.
- R2: The count changes only when the enable bit (control bit 24) is 1 and the event selector (control bits 7:0) equals 0x48. Otherwise it holds its value, unless it is written.
- R3: With mask bit 0 set, only that bit, and a threshold of 0, each cycle adds the outstanding demand-miss input `miss_pend`.
- R4: Mask bit 1 adds the blocked-request input `fb_block`, and mask bit 2 adds the allocation input `fb_alloc`. When several mask bits are set, their inputs are summed.
- R5: Mask bit 3 selects nothing. A mask of 0x8 on its own never changes the count.
- R6: With a nonzero threshold (control bits 23:16), each cycle adds 1 if the selected sum is at least the threshold and 0 otherwise. Threshold 1 with mask 0x1 therefore counts the cycles in which at least one demand miss is outstanding.
- R7: A write to address 1 loads the count with the 48 bits written. In that cycle the write replaces the increment.
- R8: The count wraps modulo 2^48. A wrap sets the wrap flag (address 2, bit 0), and the flag stays set until a write to address 2 with bit 0 set. When a wrap and a clear happen in the same cycle, the wrap wins.
- R9: The register map is as follows. Address 0 is control: bits 7:0 event selector, 15:8 mask, 23:16 threshold, 24 enable, and bits 47:25 stored and read back as written. Address 1 is the count. Address 2 holds the wrap flag in bit 0 with all other bits zero. Address 3 reads zero. Reads are combinational from `rd_addr`.
- R10: Tracker inputs sampled at a clock edge show up in the count read back after that same edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 48 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 48 | Register read data |
| miss_pend | input | OCC_W (5) | Outstanding demand-load line misses this cycle |
| fb_block | input | OCC_W (5) | Requests blocked for want of a fill buffer this cycle |
| fb_alloc | input | OCC_W (5) | Fill buffers allocated this cycle |

## Verification
A wrong selection or threshold decision shows up in the count read back one cycle after the offending input, so a per-cycle comparison catches it at once. A bad carry or flag path stays hidden until the count crosses 2^48, which is why the count is preloaded just below the top before it runs. A lost or sticky-when-it-should-clear flag is visible at address 2 on the very next read. Enable and selector gating faults appear as drift in a count that should have held.

// File: rtl/fb_event_counter.sv
`timescale 1ns/1ps
module fb_event_counter #(
  parameter int CNT_W = 48,
  parameter int OCC_W = 5,
  parameter logic [7:0] EVENT_SEL = 8'h48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [OCC_W-1:0] miss_pend,
  input  logic [OCC_W-1:0] fb_block,
  input  logic [OCC_W-1:0] fb_alloc
);
  localparam int SUM_W = OCC_W + 2;
  localparam int CMP_W = (SUM_W > 8) ? SUM_W : 8;

  logic [CNT_W-1:0] ctrl_q, cnt_q;
  logic             ovf_q;

  wire [7:0] ev_sel  = ctrl_q[7:0];
  wire [7:0] sub_msk = ctrl_q[15:8];
  wire [7:0] thresh  = ctrl_q[23:16];
  wire       cnt_en  = ctrl_q[24];

  wire wr_ctrl = wr_en && (wr_addr == 2'd0);
  wire wr_cnt  = wr_en && (wr_addr == 2'd1);
  wire clr_ovf = wr_en && (wr_addr == 2'd2) && wr_data[0];

  wire [SUM_W-1:0] sel_sum =
      (sub_msk[0] ? SUM_W'(miss_pend) : '0) +
      (sub_msk[1] ? SUM_W'(fb_block)  : '0) +
      (sub_msk[2] ? SUM_W'(fb_alloc)  : '0);

  wire             active  = cnt_en && (ev_sel == EVENT_SEL);
  wire             hit     = CMP_W'(sel_sum) >= CMP_W'(thresh);
  wire [SUM_W-1:0] step    = !active ? '0 :
                             (thresh == 8'd0) ? sel_sum : SUM_W'(hit);
  wire [CNT_W:0]   next    = {1'b0, cnt_q} + (CNT_W+1)'(step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_cnt)  cnt_q  <= wr_data;
      else         cnt_q  <= next[CNT_W-1:0];
      if (!wr_cnt && next[CNT_W]) ovf_q <= 1'b1;
      else if (clr_ovf)           ovf_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctrl_q;
      2'd1:    rd_data = cnt_q;
      2'd2:    rd_data = {{(CNT_W-1){1'b0}}, ovf_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fb_event_counter_chk.sv
`timescale 1ns/1ps
module fb_event_counter_chk #(
  parameter int CNT_W = 48,
  parameter logic [7:0] EVENT_SEL = 8'h48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q
);
  wire cw  = wr_en && (wr_addr == 2'd1);
  wire clr = wr_en && (wr_addr == 2'd2) && wr_data[0];

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[24] && !cw) |=> cnt_q == $past(cnt_q)); // R2
  AST_FOREIGN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7:0] != EVENT_SEL && !cw) |=> cnt_q == $past(cnt_q)); // R2
  AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q[10:8] == 3'd0) && !cw) |=> $stable(cnt_q)); // R5
  AST_THRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q[23:16] != 8'd0) && !cw) |=> CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1)); // R6
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> cnt_q == $past(wr_data)); // R7
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q); // R8
  AST_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (!$past(cw) && cnt_q < $past(cnt_q))); // R8
endmodule

bind fb_event_counter fb_event_counter_chk #(.CNT_W(CNT_W), .EVENT_SEL(EVENT_SEL)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .ovf_q(ovf_q));

// File: tb/fb_event_counter_tb_top.sv
`timescale 1ns/1ps
module fb_event_counter_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [47:0] wr_data = 0, rd_data;
  logic [4:0]  miss_pend = 0, fb_block = 0, fb_alloc = 0;
  int nchk = 0, nfail = 0;
  logic [47:0] m_ctrl = 0, m_cnt = 0;
  logic m_ovf = 0;

  always #10 clk = ~clk;

  fb_event_counter dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .miss_pend(miss_pend),
    .fb_block(fb_block), .fb_alloc(fb_alloc));

  function automatic logic [47:0] step_of(logic [47:0] c, logic [4:0] p, logic [4:0] b, logic [4:0] a);
    int s;
    s = (c[8] ? p : 0) + (c[9] ? b : 0) + (c[10] ? a : 0);
    if (!c[24] || c[7:0] != 8'h48) return 0;
    if (c[23:16] == 0) return 48'(s);
    return (s >= c[23:16]) ? 48'd1 : 48'd0;
  endfunction

  function automatic logic [47:0] ctl(bit en, logic [7:0] cm, logic [7:0] um, logic [7:0] ev);
    return {23'h0, en, cm, um, ev};
  endfunction

  task automatic chk(input logic [1:0] a, input logic [47:0] exp, input string req);
    rd_addr = a; #1;
    nchk++;
    if (rd_data !== exp) begin
      nfail++;
      $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [1:0] wa, input logic [47:0] wd,
                     input logic [4:0] p, input logic [4:0] b, input logic [4:0] a,
                     input string req, input bit pre = 0);
    logic [48:0] sum;
    wr_en = we; wr_addr = wa; wr_data = wd; miss_pend = p; fb_block = b; fb_alloc = a;
    if (pre) chk(2'd1, m_cnt, "R10");
    sum = {1'b0, m_cnt} + {1'b0, step_of(m_ctrl, p, b, a)};
    @(posedge clk); #1;
    wr_en = 0;
    if (we && wa == 2'd1) m_cnt = wd;
    else begin
      m_cnt = sum[47:0];
      if (sum[48]) m_ovf = 1;
      else if (we && wa == 2'd2 && wd[0]) m_ovf = 0;
    end
    if (we && wa == 2'd2 && wd[0] && sum[48] && !(we && wa == 2'd1)) m_ovf = 1;
    if (we && wa == 2'd0) m_ctrl = wd;
    chk(2'd1, m_cnt, req);
    chk(2'd2, {47'h0, m_ovf}, "R8");
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(2'd0, 48'h0, "R1"); chk(2'd1, 48'h0, "R1"); chk(2'd2, 48'h0, "R1");
    chk(2'd3, 48'h0, "R9");
    // R9 control readback including kept upper bits
    cyc(1, 2'd0, {23'h5A5A5A, 1'b1, 8'h00, 8'h01, 8'h48}, 0, 0, 0, "R9");
    chk(2'd0, {23'h5A5A5A, 1'b1, 8'h00, 8'h01, 8'h48}, "R9");
    // R3 occupancy accumulation, R10 latency
    cyc(0, 0, 0, 5'd3, 5'd9, 5'd9, "R3", 1);
    chk(2'd1, 48'd3, "R3");
    cyc(0, 0, 0, 5'd4, 0, 0, "R3", 1);
    chk(2'd1, 48'd7, "R3");
    // R4 combined sub-events
    cyc(1, 2'd0, ctl(1, 0, 8'h06, 8'h48), 0, 0, 0, "R4");
    cyc(0, 0, 0, 5'd9, 5'd2, 5'd5, "R4");
    chk(2'd1, 48'd14, "R4");
    cyc(1, 2'd0, ctl(1, 0, 8'h07, 8'h48), 0, 0, 0, "R4");
    cyc(0, 0, 0, 5'd31, 5'd31, 5'd31, "R4");
    chk(2'd1, 48'd107, "R4");
    // R5 bit 3 alone
    cyc(1, 2'd0, ctl(1, 0, 8'h08, 8'h48), 0, 0, 0, "R5");
    cyc(0, 0, 0, 5'd9, 5'd9, 5'd9, "R5");
    chk(2'd1, 48'd107, "R5");
    // R6 threshold
    cyc(1, 2'd0, ctl(1, 8'd1, 8'h01, 8'h48), 0, 0, 0, "R6");
    cyc(0, 0, 0, 5'd0, 5'd7, 5'd7, "R6");
    chk(2'd1, 48'd107, "R6");
    cyc(0, 0, 0, 5'd3, 0, 0, "R6");
    chk(2'd1, 48'd108, "R6");
    cyc(1, 2'd0, ctl(1, 8'd4, 8'h01, 8'h48), 0, 0, 0, "R6");
    cyc(0, 0, 0, 5'd3, 0, 0, "R6");
    chk(2'd1, 48'd108, "R6");
    cyc(0, 0, 0, 5'd4, 0, 0, "R6");
    chk(2'd1, 48'd109, "R6");
    // R2 gating
    cyc(1, 2'd0, ctl(0, 0, 8'h01, 8'h48), 0, 0, 0, "R2");
    cyc(0, 0, 0, 5'd5, 0, 0, "R2");
    chk(2'd1, 48'd109, "R2");
    cyc(1, 2'd0, ctl(1, 0, 8'h07, 8'h47), 0, 0, 0, "R2");
    cyc(0, 0, 0, 5'd5, 5'd5, 5'd5, "R2");
    chk(2'd1, 48'd109, "R2");
    // R7 write replaces increment
    cyc(1, 2'd0, ctl(1, 0, 8'h01, 8'h48), 0, 0, 0, "R7");
    cyc(1, 2'd1, 48'd100, 5'd7, 0, 0, "R7");
    chk(2'd1, 48'd100, "R7");
    // R8 wrap, sticky, clear, set-wins
    cyc(1, 2'd1, 48'hFFFF_FFFF_FFFE, 5'd1, 0, 0, "R8");
    cyc(0, 0, 0, 5'd5, 0, 0, "R8");
    chk(2'd1, 48'd3, "R8"); chk(2'd2, 48'd1, "R8");
    cyc(0, 0, 0, 5'd0, 0, 0, "R8");
    chk(2'd2, 48'd1, "R8");
    cyc(1, 2'd2, 48'd1, 5'd0, 0, 0, "R8");
    chk(2'd2, 48'd0, "R8");
    cyc(1, 2'd1, 48'hFFFF_FFFF_FFFF, 0, 0, 0, "R8");
    cyc(1, 2'd2, 48'd1, 5'd2, 0, 0, "R8");
    chk(2'd2, 48'd1, "R8");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 200;
      if (r < 5)
        cyc(1, 2'd0, {23'($urandom), 1'($urandom % 8 != 0),
                      ($urandom % 3 == 0) ? 8'($urandom % 6) : 8'd0,
                      8'($urandom % 16), ($urandom % 4 == 0) ? 8'h47 : 8'h48},
            5'($urandom), 5'($urandom), 5'($urandom), "R4");
      else if (r < 7)
        cyc(1, 2'd1, ($urandom % 2) ? 48'hFFFF_FFFF_FF00 + 48'($urandom % 256)
                                    : {16'($urandom), 32'($urandom)},
            5'($urandom), 5'($urandom), 5'($urandom), "R7");
      else if (r < 9)
        cyc(1, 2'd2, 48'd1, 5'($urandom), 5'($urandom), 5'($urandom), "R8");
      else
        cyc(0, 0, 0, 5'($urandom), 5'($urandom), 5'($urandom), "R6");
    end
    chk(2'd0, m_ctrl, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule